// File: doc/BRIEF.md
# Subpixel Sprite Position Updater

This block keeps the screen coordinates of two game objects on a 720 by 507 pixel playfield. A paddle moves along the vertical axis in whole pixels. On every frame strobe its position changes by a signed 8-bit velocity. A ball moves in both axes and is held in fixed point: a 10-bit integer pixel with an 8-bit fraction below it, so one step is 1/256 of a pixel. On every subframe strobe (256 subframes make one frame), each ball axis adds its own signed velocity, given in 1/256-pixel units. Because a frame holds 256 subframes, a ball velocity of v subpixels per subframe moves the ball v pixels per frame.

The renderer does not read the fine position directly. On each frame strobe the block copies the integer part of each ball axis into an output register. That value then holds steady until the next frame strobe, while the fine position keeps moving. All positions stop at the playfield edges (zero and the size minus one) and do not wrap. A load strobe places both objects at given pixel positions.

The block has no collision response and produces no video timing. Those are handled elsewhere.

Top module: `sprite_pos_updater`

## Requirements
- R1: While reset is asserted, and for two clock edges after it is released, every output reads zero.
- R2: When load_i is high at a clock edge, the paddle and the ball integer positions take the init inputs and the ball fractions become zero. Each value is clamped to its axis size minus one. The ball outputs show the loaded pixels after that edge. Load overrides any strobe in the same cycle.
- R3: At a frame strobe, the paddle position becomes its old value plus pad_vel_i, read as two's complement. The new value appears on pad_y_o after that edge. With no frame strobe the paddle holds.
- R4: The paddle result is limited to the range 0 to 506. A sum below zero gives 0 and a sum above 506 gives 506.
- R5: At a subframe strobe, each ball axis adds its two's complement velocity to an 18-bit position in 1/256-pixel units. A negative step taken from a whole pixel lands in the fraction of the pixel below it.
- R6: At a frame strobe, ball_x_o and ball_y_o take bits 17:8 of the ball positions. Between frame strobes they hold their value while subframe strobes keep moving the ball.
- R7: When a frame strobe and a subframe strobe come in the same cycle, the subframe step is applied first. The rendered pixel comes from the stepped position.
- R8: Ball positions are limited to the range 0 to (size−1)×256 subpixels: 719×256 for x and 506×256 for y. Results outside this range clamp to the nearer limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Load the init positions |
| pad_init_i | input | 10 | Initial paddle y pixel |
| ball_x_init_i | input | 10 | Initial ball x pixel |
| ball_y_init_i | input | 10 | Initial ball y pixel |
| pad_vel_i | input | 8 | Paddle velocity, signed, pixels per frame |
| ball_vx_i | input | 8 | Ball x velocity, signed, subpixels per subframe |
| ball_vy_i | input | 8 | Ball y velocity, signed, subpixels per subframe |
| subframe_i | input | 1 | Subframe strobe |
| frame_i | input | 1 | Frame strobe |
| pad_y_o | output | 10 | Paddle y pixel |
| ball_x_o | output | 10 | Rendered ball x pixel |
| ball_y_o | output | 10 | Rendered ball y pixel |

## Verification
Each strobe or load sampled at a rising edge appears on the outputs right after that same edge, so every result is due one cycle after it is driven. The only exception is reset release, which waits two further edges in the internal synchronizer. The bench drives inputs on the falling edge. A behavioural model steps on the rising edge with the same inputs, and all three outputs are compared with it on every falling edge. Every result is therefore checked in the cycle it becomes due, and every hold cycle is checked too.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int PIX_W   = 10;
  localparam int FRAC_W  = 8;
  localparam int VEL_W   = 8;
  localparam int FIELD_W = 720;
  localparam int FIELD_H = 507;
  localparam int BALL_AXES = 2;
endpackage

// File: rtl/sat_step.sv
module sat_step #(
  parameter int POS_W = 10,
  parameter int VEL_W = 8,
  parameter int MAX   = 506
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [VEL_W-1:0] vel_i,
  output logic [POS_W-1:0] pos_o
);
  localparam int SW = POS_W + 2;

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] vel_ext;

  always_comb begin
    vel_ext = $signed({{(SW-VEL_W){vel_i[VEL_W-1]}}, vel_i});
    sum     = $signed({2'b00, pos_i}) + vel_ext;
    if (sum < 0)
      pos_o = '0;
    else if (sum > $signed(SW'(MAX)))
      pos_o = POS_W'(MAX);
    else
      pos_o = sum[POS_W-1:0];
  end
endmodule

// File: rtl/paddle_axis.sv
module paddle_axis #(
  parameter int PIX_W = 10,
  parameter int VEL_W = 8,
  parameter int LIMIT = 507
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PIX_W-1:0] init_i,
  input  logic             step_i,
  input  logic [VEL_W-1:0] vel_i,
  output logic [PIX_W-1:0] pos_o
);
  localparam logic [PIX_W-1:0] TOP = PIX_W'(LIMIT - 1);

  logic [PIX_W-1:0] pos_q, pos_d, stepped, init_cl;
  logic             pos_en;

  sat_step #(.POS_W(PIX_W), .VEL_W(VEL_W), .MAX(LIMIT - 1)) u_step (
    .pos_i(pos_q), .vel_i(vel_i), .pos_o(stepped)
  );

  always_comb begin
    init_cl = (init_i > TOP) ? TOP : init_i;
    pos_en  = load_i | step_i;
    pos_d   = load_i ? init_cl : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  a_r3_hold_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(pos_o));
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_o <= TOP);
endmodule

// File: rtl/ball_axis.sv
module ball_axis #(
  parameter int PIX_W  = 10,
  parameter int FRAC_W = 8,
  parameter int VEL_W  = 8,
  parameter int LIMIT  = 720
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PIX_W-1:0] init_i,
  input  logic             sub_i,
  input  logic             frame_i,
  input  logic [VEL_W-1:0] vel_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int POS_W   = PIX_W + FRAC_W;
  localparam int MAX_SUB = (LIMIT - 1) * (2 ** FRAC_W);
  localparam logic [PIX_W-1:0] TOP = PIX_W'(LIMIT - 1);

  logic [POS_W-1:0] sub_q, sub_d, stepped;
  logic [PIX_W-1:0] rend_q, rend_d, init_cl;
  logic             sub_en, rend_en;

  sat_step #(.POS_W(POS_W), .VEL_W(VEL_W), .MAX(MAX_SUB)) u_step (
    .pos_i(sub_q), .vel_i(vel_i), .pos_o(stepped)
  );

  always_comb begin
    init_cl = (init_i > TOP) ? TOP : init_i;
    sub_en  = load_i | sub_i;
    sub_d   = load_i ? {init_cl, {FRAC_W{1'b0}}} : stepped;
    rend_en = load_i | frame_i;
    if (load_i)     rend_d = init_cl;
    else if (sub_i) rend_d = stepped[POS_W-1:FRAC_W];
    else            rend_d = sub_q[POS_W-1:FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sub_q <= '0;
    else if (sub_en) sub_q <= sub_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rend_q <= '0;
    else if (rend_en) rend_q <= rend_d;
  end

  assign pix_o = rend_q;

  a_r5_hold_without_subframe: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !sub_i) |=> $stable(sub_q));
  a_r6_render_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !frame_i) |=> $stable(pix_o));
  a_r7_render_tracks_position: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i || load_i) |=> (pix_o == sub_q[POS_W-1:FRAC_W]));
  a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= POS_W'(MAX_SUB));
endmodule

// File: rtl/sprite_pos_updater.sv
module sprite_pos_updater
  import sprite_pkg::*;
#(
  parameter int P_PIX_W   = PIX_W,
  parameter int P_FRAC_W  = FRAC_W,
  parameter int P_VEL_W   = VEL_W,
  parameter int P_FIELD_W = FIELD_W,
  parameter int P_FIELD_H = FIELD_H
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [P_PIX_W-1:0] pad_init_i,
  input  logic [P_PIX_W-1:0] ball_x_init_i,
  input  logic [P_PIX_W-1:0] ball_y_init_i,
  input  logic [P_VEL_W-1:0] pad_vel_i,
  input  logic [P_VEL_W-1:0] ball_vx_i,
  input  logic [P_VEL_W-1:0] ball_vy_i,
  input  logic               subframe_i,
  input  logic               frame_i,
  output logic [P_PIX_W-1:0] pad_y_o,
  output logic [P_PIX_W-1:0] ball_x_o,
  output logic [P_PIX_W-1:0] ball_y_o
);
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  paddle_axis #(.PIX_W(P_PIX_W), .VEL_W(P_VEL_W), .LIMIT(P_FIELD_H)) u_pad (
    .clk(clk), .rst_n(rst_core_n), .load_i(load_i), .init_i(pad_init_i),
    .step_i(frame_i), .vel_i(pad_vel_i), .pos_o(pad_y_o)
  );

  logic [BALL_AXES-1:0][P_PIX_W-1:0] b_init, b_pix;
  logic [BALL_AXES-1:0][P_VEL_W-1:0] b_vel;

  assign b_init = {ball_y_init_i, ball_x_init_i};
  assign b_vel  = {ball_vy_i, ball_vx_i};

  for (genvar a = 0; a < BALL_AXES; a++) begin : g_ball
    localparam int LIM = (a == 0) ? P_FIELD_W : P_FIELD_H;
    ball_axis #(.PIX_W(P_PIX_W), .FRAC_W(P_FRAC_W), .VEL_W(P_VEL_W), .LIMIT(LIM)) u_axis (
      .clk(clk), .rst_n(rst_core_n), .load_i(load_i), .init_i(b_init[a]),
      .sub_i(subframe_i), .frame_i(frame_i), .vel_i(b_vel[a]), .pix_o(b_pix[a])
    );
  end

  assign ball_x_o = b_pix[0];
  assign ball_y_o = b_pix[1];

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst_core_n)
    (pad_y_o == '0) && (ball_x_o == '0) && (ball_y_o == '0));
endmodule

// File: tb/sim_sprite_pos_updater.sv
module sim_sprite_pos_updater;
  localparam int FW = 720;
  localparam int FH = 507;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       load = 1'b0, sub = 1'b0, frame = 1'b0;
  logic [9:0] pad_init = '0, bx_init = '0, by_init = '0;
  logic [7:0] pad_vel = '0, vx = '0, vy = '0;
  logic [9:0] pad_y, ball_x, ball_y;

  sprite_pos_updater u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load), .pad_init_i(pad_init),
    .ball_x_init_i(bx_init), .ball_y_init_i(by_init), .pad_vel_i(pad_vel),
    .ball_vx_i(vx), .ball_vy_i(vy), .subframe_i(sub), .frame_i(frame),
    .pad_y_o(pad_y), .ball_x_o(ball_x), .ball_y_o(ball_y)
  );

  int    errors = 0, checks = 0;
  string phase = "R1";
  int    m_pad = 0, m_bx = 0, m_by = 0, m_rx = 0, m_ry = 0;
  int    s1 = 0, s2 = 0;
  bit    finished = 0;

  function automatic int clampi(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int sx8(logic [7:0] v);
    return int'($signed(v));
  endfunction

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0;
      m_pad = 0; m_bx = 0; m_by = 0; m_rx = 0; m_ry = 0;
    end else begin
      if (s2 == 0) begin
        m_pad = 0; m_bx = 0; m_by = 0; m_rx = 0; m_ry = 0;
      end else if (load) begin
        m_pad = clampi(int'(pad_init), FH - 1);
        m_rx  = clampi(int'(bx_init), FW - 1);
        m_ry  = clampi(int'(by_init), FH - 1);
        m_bx  = m_rx * 256;
        m_by  = m_ry * 256;
      end else begin
        if (sub) begin
          m_bx = clampi(m_bx + sx8(vx), (FW - 1) * 256);
          m_by = clampi(m_by + sx8(vy), (FH - 1) * 256);
        end
        if (frame) begin
          m_pad = clampi(m_pad + sx8(pad_vel), FH - 1);
          m_rx  = m_bx / 256;
          m_ry  = m_by / 256;
        end
      end
      s2 = s1; s1 = 1;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("pad_y_o", int'(pad_y), m_pad);
      cmp("ball_x_o", int'(ball_x), m_rx);
      cmp("ball_y_o", int'(ball_y), m_ry);
    end
  end

  task automatic cyc(bit s, bit f);
    @(negedge clk);
    sub = s; frame = f; load = 1'b0;
  endtask

  task automatic do_load(int p, int x, int y);
    @(negedge clk);
    pad_init = 10'(p); bx_init = 10'(x); by_init = 10'(y);
    load = 1'b1; sub = 1'b0; frame = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state and synchronized release
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) cyc(0, 0);

    // R2: load, then load colliding with strobes, then clamped init
    phase = "R2";
    do_load(100, 200, 300);
    cyc(0, 0);
    pad_vel = 8'd9; vx = 8'd50; vy = 8'd50;
    @(negedge clk);
    pad_init = 10'd120; bx_init = 10'd40; by_init = 10'd60;
    load = 1'b1; sub = 1'b1; frame = 1'b1;
    cyc(0, 0);
    do_load(1000, 1023, 900);
    cyc(0, 0);
    do_load(100, 200, 300);
    pad_vel = 8'd0; vx = 8'd0; vy = 8'd0;
    cyc(0, 0);

    // R3: paddle steps with positive and negative velocity
    phase = "R3";
    pad_vel = 8'd5;
    repeat (3) begin cyc(0, 1); cyc(0, 0); end
    pad_vel = 8'hFD;
    repeat (2) cyc(0, 1);
    repeat (3) cyc(0, 0);

    // R4: paddle clamps at both ends
    phase = "R4";
    pad_vel = 8'h80;
    repeat (3) cyc(0, 1);
    pad_vel = 8'd127;
    repeat (6) cyc(0, 1);
    cyc(0, 0);

    // R5: negative subpixel step crosses into the pixel below
    phase = "R5";
    pad_vel = 8'd0;
    do_load(50, 10, 10);
    vx = 8'hFF; vy = 8'd37;
    repeat (5) cyc(1, 0);
    cyc(0, 1);
    cyc(0, 0);

    // R6: long run, render only at every 256th subframe
    phase = "R6";
    vx = 8'd37; vy = 8'hEC;
    for (int i = 0; i < 600; i++) cyc(1, (i % 256) == 255);
    cyc(0, 0);

    // R7: coincident frame and subframe strobes
    phase = "R7";
    do_load(50, 100, 100);
    vx = 8'd128 - 8'd1; vy = 8'hC0;
    cyc(1, 1);
    cyc(1, 0); cyc(1, 0);
    cyc(1, 1);
    cyc(0, 0);

    // R8: ball clamps at the far and near edges
    phase = "R8";
    do_load(50, 715, 500);
    vx = 8'd127; vy = 8'd127;
    for (int i = 0; i < 100; i++) cyc(1, (i % 20) == 19);
    cyc(0, 1);
    vx = 8'h80; vy = 8'h80;
    for (int i = 0; i < 1500; i++) cyc(1, (i % 100) == 99);
    cyc(0, 1);
    repeat (3) cyc(0, 0);

    finish_run();
  end
endmodule